// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns bytes into an asynchronous serial bit stream. A one-entry holding register takes each write. A frame shifter empties the holding register at every character boundary. A character is a low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. Bit timing comes from an external `bit_tick` strobe, which pulses once per bit time. Each strobe advances the line by one bit.

The transmitter can also send two kinds of character that carry no data. When the enable is raised, the block first sends one idle character, which is all ones. While the break request is held, it sends break characters, which are all zeros. Both kinds last a full character length and have no framing bits. Two status flags let software stream without gaps. The empty flag shows that the holding register may be written. The complete flag shows that the line has gone quiet with nothing left to send.

Top module: `sertx_brk`

## Requirements
- R1: After reset `txd` is high and `status` reads 8'hC0. Bit 7 is the empty flag, bit 6 is the complete flag, and bits 5..0 always read 0.
- R2: With `long_mode`=0 a character lasts 10 bit times: a start bit of 0, then `wr_data` bits 0 to 7, then a stop bit of 1.
- R3: With `long_mode`=1 a character lasts 11 bit times. The value of `wr_bit8` is sent between data bit 7 and the stop bit.
- R4: After `tx_en` rises, the first character sent is one character length of ones. Any waiting data follows it.
- R5: A write clears both the empty flag and the complete flag. The empty flag sets again in the same cycle that the waiting word starts shifting.
- R6: When a word is waiting at a character boundary, its start bit follows the previous stop bit directly, with no extra high bit.
- R7: The complete flag sets on a character boundary at which nothing is waiting to be sent.
- R8: A break request takes effect at the next character boundary and never cuts a character short. While it is held, the block sends back-to-back break characters of 10 zeros, or 11 zeros when `long_mode`=1. Break characters have priority over waiting data.
- R9: After the break request is released, the line stays high for at least one bit time before the next start bit.
- R10: While `tx_en` is low, `txd` is high from the next cycle onward, `bit_tick` strobes shift nothing, and a written word stays waiting.
- R11: A write in the same cycle as a boundary strobe is never lost. If the holding register was full, the older word starts and the new word waits. If the holding register was empty, the new word waits and the complete flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit time |
| tx_en | input | 1 | Transmitter enable |
| long_mode | input | 1 | 1 selects 11-bit characters, 0 selects 10-bit characters |
| brk_req | input | 1 | Hold high to send break characters |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data byte to send |
| wr_bit8 | input | 1 | Ninth data bit, used when `long_mode`=1 |
| txd | output | 1 | Serial line |
| status | output | 8 | Bit 7 is the empty flag, bit 6 is the complete flag, other bits are 0 |

## Verification
Two functions can fall in the same clock cycle: a software write and the boundary strobe that empties the holding register. The bench provokes this by raising `wr_stb` and `bit_tick` in one cycle. It does so once while a word is already waiting, and once while the holding register is empty. Each case is judged in two ways. The bench checks the bit that appears on `txd` after that strobe. It also checks the status byte, which must show that the new word is waiting and that the complete flag is clear. The bench then replays every later frame bit by bit to confirm that no word was lost or sent twice.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DW       = 8;
    localparam int FW       = DW + 3;
    localparam int CNT_W    = $clog2(FW + 1);
    localparam int STAT_W   = 8;
    localparam int ST_EMPTY = 7;
    localparam int ST_DONE  = 6;

    typedef struct packed {
        logic          b8;
        logic [DW-1:0] d;
    } tx_word_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_PRE,
        K_BRK,
        K_GAP,
        K_DATA
    } char_kind_e;

    // Framed character, bit 0 goes on the line first.
    function automatic logic [FW-1:0] frame_of(tx_word_t w, logic lng);
        return lng ? {1'b1, w.b8, w.d, 1'b0} : {2'b11, w.d, 1'b0};
    endfunction

    function automatic logic [CNT_W-1:0] char_len(logic lng);
        return lng ? CNT_W'(FW) : CNT_W'(FW - 1);
    endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_stb,
    input  tx_word_t wr_word,
    input  logic     xfer,
    input  logic     idle_set,
    output logic     full,
    output tx_word_t word,
    output logic     done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            done <= 1'b1;
            word <= '0;
        end else begin
            if (wr_stb) begin
                word <= wr_word;
                full <= 1'b1;
                done <= 1'b0;
            end else begin
                if (xfer)
                    full <= 1'b0;
                if (idle_set)
                    done <= 1'b1;
            end
        end
    end

    assert_write_clears_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (full && !done));
    assert_word_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (full && !xfer) |=> full);
    assert_done_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (idle_set && !wr_stb) |=> done);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_tick,
    input  logic     tx_en,
    input  logic     long_mode,
    input  logic     brk_req,
    input  logic     hold_full,
    input  tx_word_t hold_word,
    output logic     xfer,
    output logic     idle_set,
    output logic     line
);
    logic             busy;
    logic [FW-1:0]    frame;
    logic [CNT_W-1:0] left;
    logic             en_q;
    logic             pre_pend;
    logic             brk_last;
    logic             boundary;
    char_kind_e       kind;

    // A boundary is a strobe that ends the last bit, or a strobe while the line is quiet.
    assign boundary = bit_tick && tx_en && en_q && (!busy || left == CNT_W'(1));

    always_comb begin
        if (pre_pend)       kind = K_PRE;
        else if (brk_req)   kind = K_BRK;
        else if (brk_last)  kind = K_GAP;
        else if (hold_full) kind = K_DATA;
        else                kind = K_NONE;
    end

    assign xfer     = boundary && (kind == K_DATA);
    assign idle_set = boundary && (kind == K_NONE);
    assign line     = busy ? frame[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            frame    <= '1;
            left     <= '0;
            en_q     <= 1'b0;
            pre_pend <= 1'b0;
            brk_last <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (!tx_en) begin
                busy     <= 1'b0;
                pre_pend <= 1'b0;
                brk_last <= 1'b0;
            end else begin
                if (!en_q)
                    pre_pend <= 1'b1;
                if (boundary) begin
                    busy     <= (kind != K_NONE);
                    brk_last <= (kind == K_BRK);
                    left     <= char_len(long_mode);
                    unique case (kind)
                        K_PRE: begin
                            frame    <= '1;
                            pre_pend <= 1'b0;
                        end
                        K_BRK:   frame <= '0;
                        K_GAP: begin
                            frame <= '1;
                            left  <= CNT_W'(1);
                        end
                        K_DATA:  frame <= frame_of(hold_word, long_mode);
                        default: frame <= '1;
                    endcase
                end else if (bit_tick && busy) begin
                    frame <= {1'b1, frame[FW-1:1]};
                    left  <= left - CNT_W'(1);
                end
            end
        end
    end

    assert_high_before_start_R9: assert property (@(posedge clk) disable iff (rst)
        xfer |-> line);
    assert_break_low_R8: assert property (@(posedge clk) disable iff (rst)
        (boundary && brk_req && !pre_pend) |=> !line);
    assert_disabled_high_R10: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (line && !xfer));
endmodule

// File: rtl/sertx_brk.sv
module sertx_brk
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              long_mode,
    input  logic              brk_req,
    input  logic              wr_stb,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_bit8,
    output logic              txd,
    output logic [STAT_W-1:0] status
);
    tx_word_t wr_word;
    tx_word_t hold_word;
    logic     hold_full;
    logic     done;
    logic     xfer;
    logic     idle_set;

    assign wr_word = '{b8: wr_bit8, d: wr_data};

    sertx_hold hold_i (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_word  (wr_word),
        .xfer     (xfer),
        .idle_set (idle_set),
        .full     (hold_full),
        .word     (hold_word),
        .done     (done)
    );

    sertx_shift shift_i (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .long_mode (long_mode),
        .brk_req   (brk_req),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .xfer      (xfer),
        .idle_set  (idle_set),
        .line      (txd)
    );

    always_comb begin
        status           = '0;
        status[ST_EMPTY] = !hold_full;
        status[ST_DONE]  = done;
    end

    assert_flags_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (status == 8'hC0 && txd));
endmodule

// File: tb/sertx_brk_tb_top.sv
module sertx_brk_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       long_mode = 1'b0;
    logic       brk_req = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_bit8 = 1'b0;
    logic       txd;
    logic [7:0] status;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sertx_brk dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en),
        .long_mode(long_mode), .brk_req(brk_req), .wr_stb(wr_stb),
        .wr_data(wr_data), .wr_bit8(wr_bit8), .txd(txd), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick1(output logic v);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        v = txd;
    endtask

    task automatic tick_wr(input int w, output logic v);
        @(negedge clk);
        bit_tick = 1'b1; wr_stb = 1'b1; wr_data = w[7:0]; wr_bit8 = w[8];
        @(negedge clk);
        bit_tick = 1'b0; wr_stb = 1'b0;
        v = txd;
    endtask

    task automatic write(input int w);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = w[7:0]; wr_bit8 = w[8];
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic grab(input int n, output logic [31:0] got);
        logic b;
        got = '0;
        for (int i = 0; i < n; i++) begin
            tick1(b);
            got[i] = b;
        end
    endtask

    // Expected frame: start 0 at bit 0, data shifted up by one, stop at bit n-1.
    function automatic int frm(input int v, input int n);
        return (v << 1) | (1 << (n - 1));
    endfunction

    task automatic sweep(input int n, input int count, input string req);
        logic        b;
        logic [31:0] rest;
        write(0);
        for (int k = 0; k < count; k++) begin
            tick1(b);
            chk("R5 empty sets on transfer", int'(status), 8'h80);
            if (k + 1 < count) begin
                write(k + 1);
                chk("R5 write clears flags", int'(status), 8'h00);
            end
            grab(n - 1, rest);
            chk(req, int'({rest[30:0], b}) & ((1 << n) - 1), frm(k, n));
        end
        tick1(b);
        chk("R7 complete at quiet boundary", int'({status, 7'b0, b}), int'({8'hC0, 8'h01}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic        b;
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset line", int'(txd), 1);
        chk("R1 reset status", int'(status), 8'hC0);
        grab(4, got);
        chk("R10 disabled line high", int'(got[3:0]), 4'hF);

        // Enable, preamble then back-to-back sweep of all bytes.
        @(negedge clk) tx_en = 1'b1;
        write(8'h00);
        chk("R5 write clears flags", int'(status), 8'h00);
        grab(10, got);
        chk("R4 idle preamble", int'(got[15:0]), 16'h03FF);
        chk("R4 data still waiting", int'(status), 8'h00);
        // The preamble's boundary starts byte 0 inside sweep's first tick.
        begin
            logic [31:0] rest;
            for (int k = 0; k < 256; k++) begin
                tick1(b);
                chk("R6 start follows stop", int'(b), 0);
                chk("R5 empty sets on transfer", int'(status), 8'h80);
                if (k < 255) write(k + 1);
                grab(9, rest);
                chk("R2 short frame", int'({rest[8:0], b}), frm(k, 10));
            end
            tick1(b);
            chk("R7 complete at quiet boundary", int'(status), 8'hC0);
            chk("R7 line idle", int'(b), 1);
        end

        // Long characters, all nine-bit values.
        @(negedge clk) long_mode = 1'b1;
        sweep(11, 512, "R3 long frame");

        // Write colliding with boundary strobe.
        @(negedge clk) long_mode = 1'b0;
        write(8'h5A);
        tick1(b);
        write(8'hC3);
        grab(9, got);
        chk("R2 frame A", int'({got[8:0], b}), frm(8'h5A, 10));
        tick_wr(8'h81, b);
        chk("R11 older word starts", int'(b), 0);
        chk("R11 new word waits", int'(status), 8'h00);
        grab(9, got);
        chk("R6 frame B", int'({got[8:0], b}), frm(8'hC3, 10));
        tick1(b);
        chk("R11 held word starts", int'(b), 0);
        chk("R11 status after start", int'(status), 8'h80);
        grab(9, got);
        chk("R11 frame C", int'({got[8:0], b}), frm(8'h81, 10));
        tick_wr(8'h3C, b);
        chk("R11 empty collision line", int'(b), 1);
        chk("R11 write beats complete", int'(status), 8'h00);
        tick1(b);
        grab(9, got);
        chk("R11 frame D", int'({got[8:0], b}), frm(8'h3C, 10));
        tick1(b);
        chk("R7 complete after D", int'(status), 8'hC0);

        // Break requested mid-frame, data waiting through break.
        write(8'h96);
        tick1(b);
        brk_req = 1'b1;
        grab(9, got);
        chk("R8 frame not cut", int'({got[8:0], b}), frm(8'h96, 10));
        write(8'h4B);
        grab(20, got);
        chk("R8 two break chars", int'(got[19:0]), 0);
        chk("R8 data held during break", int'(status), 8'h00);
        brk_req = 1'b0;
        tick1(b);
        chk("R9 high after break", int'(b), 1);
        grab(10, got);
        chk("R9 frame after gap", int'(got[9:0]), frm(8'h4B, 10));
        tick1(b);
        chk("R7 complete after break", int'(status), 8'hC0);

        // Long break length.
        @(negedge clk) long_mode = 1'b1;
        brk_req = 1'b1;
        grab(11, got);
        chk("R8 long break zeros", int'(got[10:0]), 0);
        brk_req = 1'b0;
        tick1(b);
        chk("R8 long break is 11 bits", int'(b), 1);
        tick1(b);
        chk("R9 idle after gap", int'({status, 7'b0, b}), int'({8'hC0, 8'h01}));

        // Disable mid-frame.
        @(negedge clk) long_mode = 1'b0;
        write(8'h32);
        tick1(b);
        tick1(b);
        chk("R2 bit0 low", int'(b), 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R10 line high when disabled", int'(txd), 1);
        write(8'hA5);
        grab(5, got);
        chk("R10 no shifting", int'(got[4:0]), 5'h1F);
        chk("R10 word kept", int'(status), 8'h00);
        tx_en = 1'b1;
        grab(10, got);
        chk("R4 preamble on re-enable", int'(got[9:0]), 10'h3FF);
        grab(10, got);
        chk("R10 kept word sent", int'(got[9:0]), frm(8'hA5, 10));
        tick1(b);
        chk("R7 final complete", int'(status), 8'hC0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule